// File: doc/BRIEF.md
# Two-Channel DMA Bus Ownership Arbiter

This block decides, cycle by cycle, who owns the system bus: DMA channel 0, DMA channel 1 or the CPU. Each channel is configured for burst operation (it keeps the bus from its first unit until the end of its transfer) or cycle-steal operation (it gives the bus up after every transfer unit). Channel 0 always ranks above channel 1. The channel engines report each finished transfer unit and the end of a whole transfer, and the arbiter moves the grant only at those unit boundaries.

A burst on channel 1 that channel 0 interrupts resumes in a way set by channel 0's mode. A bursting channel 0 keeps the bus until its transfer ends. A cycle-stealing channel 0 hands the bus back to channel 1 after each of its units, so the two alternate and the CPU stays off the bus until channel 1's burst ends. The block also rejects illegal channel setups, and it turns falling edges on an active-low serial-peripheral request line into single latched requests.

Top module: `dmaarb_bus_arbiter`

## Requirements
- R1: `rst_n` is a synchronous active-low reset. While it is low and on the first cycle after it, `grant` is 3'b100 (CPU). Reset clears every latched serial request. A serial line that is already low when reset ends does not count as a new edge.
- R2: `grant` is always one-hot. Bit 0 is channel 0, bit 1 is channel 1 and bit 2 is the CPU. The CPU holds the grant whenever no channel has a request and no burst is in progress.
- R3: While a channel owns the bus, the grant does not change until that channel pulses its `unit_done` bit. `unit_done` from a channel that does not own the bus is ignored.
- R4: When channel 1 finishes a unit while channel 0 is requesting, the next grant goes to channel 0. This holds even in the middle of a channel 1 burst.
- R5: A burst-mode channel 0 keeps the grant across unit boundaries until it finishes a unit with `xfer_done` high. Only then does an interrupted channel 1 burst resume.
- R6: When a cycle-steal channel 0 finishes a unit while a channel 1 burst is still unfinished, the next grant goes to channel 1. The pattern while channel 0 keeps requesting is therefore ch1, ch0, ch1, ch0.
- R7: While a channel 1 burst is unfinished, the CPU is never granted.
- R8: A cycle-steal channel returns the grant to the CPU after each unit when no interrupted burst is waiting. A request that is still present wins the bus back one cycle later.
- R9: Source codes are 0 external, 1 auto, 2 serial peripheral and 3 reserved. Unit size codes are 0 for 1 byte, 1 for 2, 2 for 4 and 3 for 16. An enabled channel is illegal in any of these cases: source code 3; serial source with burst mode; single-address mode (`ch_dual`=0) with size code 3; single-address mode with any source other than external. An illegal channel raises its `cfg_err` bit at once and never receives the grant. Disabled channels show no error.
- R10: With the serial source, requests come only from falling edges of `ser_req_n`, and each edge latches exactly one request. The request is taken into account from the second clock edge after the line falls. It stays pending until that channel is granted and finishes a unit. `lvl_req` is ignored for such a channel.
- R11: With the external or auto source, the channel requests while its `lvl_req` bit is high, and `ser_req_n` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_en | input | 2 | Per-channel enable |
| ch_burst | input | 2 | Per-channel mode: 1 burst, 0 cycle-steal |
| ch_dual | input | 2 | Per-channel addressing: 1 dual, 0 single |
| ch_src | input | 4 | Request source code, 2 bits per channel (channel c at [2c+1:2c]) |
| ch_usize | input | 4 | Unit size code, 2 bits per channel |
| lvl_req | input | 2 | Level request for the external or auto source |
| ser_req_n | input | 2 | Active-low serial-peripheral request line, edge detected |
| unit_done | input | 2 | Channel engine finished one transfer unit |
| xfer_done | input | 2 | Qualifies unit_done as the last unit of the transfer |
| grant | output | 3 | One-hot bus owner: bit0 ch0, bit1 ch1, bit2 CPU |
| cfg_err | output | 2 | Illegal configuration flag per enabled channel |

## Verification
The assertions assume the channel engines behave: `unit_done` and `xfer_done` are pulsed only by the owning channel, and configuration stays fixed while that channel is mid-transfer. The stimulus changes configuration only while the CPU owns the bus and no burst is open. It pulses `unit_done` only on the owning channel, and it raises `xfer_done` only together with that channel's final `unit_done`. Inputs change on the falling clock edge. Every request line is lowered before a scenario ends, so each scenario starts from the idle CPU-owned state.

// File: rtl/dmaarb_pkg.sv
// Shared constants and encodings for the two-channel DMA bus arbiter.
// Assumes exactly two channels; the CPU takes the grant index after them.
package dmaarb_pkg;
    localparam int NCH     = 2;
    localparam int SRC_W   = 2;
    localparam int SZ_W    = 2;
    localparam int GNT_W   = NCH + 1;
    localparam int CPU_IDX = NCH;

    typedef enum logic [SRC_W-1:0] {
        SRC_EXT  = 2'd0,
        SRC_AUTO = 2'd1,
        SRC_SER  = 2'd2,
        SRC_RSV  = 2'd3
    } src_e;

    typedef enum logic [SZ_W-1:0] {
        SZ_1  = 2'd0,
        SZ_2  = 2'd1,
        SZ_4  = 2'd2,
        SZ_16 = 2'd3
    } usize_e;

    typedef enum logic [1:0] {
        OWN_CH0 = 2'd0,
        OWN_CH1 = 2'd1,
        OWN_CPU = 2'd2
    } owner_e;
endpackage

// File: rtl/dmaarb_cfg_check.sv
// Configuration legality check for one channel.
// Purely combinational; assumes configuration is quasi-static.
// A channel is usable (legal) only when enabled and free of every rule
// violation; err is raised only for an enabled channel.
module dmaarb_cfg_check
    import dmaarb_pkg::*;
(
    input  logic             en,
    input  logic             burst,
    input  logic             dual,
    input  logic [SRC_W-1:0] src,
    input  logic [SZ_W-1:0]  usize,
    output logic             legal,
    output logic             err
);
    logic bad_src;
    logic bad_mode;
    logic bad_size;
    logic bad_single;
    logic illegal;

    // Evaluate each legality rule and combine them.
    always_comb begin
        bad_src    = (src_e'(src) == SRC_RSV);
        bad_mode   = burst && (src_e'(src) == SRC_SER);
        bad_size   = !dual && (usize_e'(usize) == SZ_16);
        bad_single = !dual && (src_e'(src) != SRC_EXT);
        illegal    = bad_src || bad_mode || bad_size || bad_single;
        legal      = en && !illegal;
        err        = en && illegal;
    end
endmodule

// File: rtl/dmaarb_req_src.sv
// Request source for one channel.
// Serial source: a falling edge on the active-low line latches one
// request, held until the channel finishes a granted unit. Other sources:
// the level request passes straight through. Assumes line_n is already
// synchronous to clk.
module dmaarb_req_src
    import dmaarb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic legal,
    input  logic is_ser,
    input  logic lvl_req,
    input  logic line_n,
    input  logic own_done,
    output logic req
);
    logic line_q;
    logic pend_q;
    logic fall;

    // Sample the line; during reset track it so no false edge appears.
    always_ff @(posedge clk) begin
        line_q <= line_n;
    end

    assign fall = line_q && !line_n;

    // Latch one request per falling edge; clear on the granted unit's end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (!legal || !is_ser) begin
            pend_q <= 1'b0;
        end else if (fall) begin
            pend_q <= 1'b1;
        end else if (own_done) begin
            pend_q <= 1'b0;
        end
    end

    // Select the request seen by the arbiter.
    always_comb begin
        req = legal && (is_ser ? pend_q : lvl_req);
    end

    // R10: a latched serial request survives until its unit completes.
    p_pend_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && legal && is_ser && !own_done) |=> pend_q);
endmodule

// File: rtl/dmaarb_grant_ctl.sv
// Bus ownership state machine for two prioritised DMA channels and a CPU.
// Moves ownership only when the CPU owns the bus or the owning channel
// reports a finished unit. Tracks an open burst per channel so that an
// interrupted burst resumes and keeps the CPU off the bus.
// Assumes unit_done/xfer_done are asserted only by the owning channel.
module dmaarb_grant_ctl
    import dmaarb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   req,
    input  logic [NCH-1:0]   burst,
    input  logic [NCH-1:0]   legal,
    input  logic [NCH-1:0]   unit_done,
    input  logic [NCH-1:0]   xfer_done,
    output logic [GNT_W-1:0] grant,
    output logic [NCH-1:0]   own_done
);
    owner_e         owner_q;
    owner_e         owner_d;
    logic [NCH-1:0] act_q;
    logic [NCH-1:0] act_keep;
    logic [NCH-1:0] act_d;
    logic [NCH-1:0] owns;

    // Fixed-priority choice used at a free boundary.
    function automatic owner_e pick(input logic r0, input logic w1);
        if (r0) begin
            return OWN_CH0;
        end else if (w1) begin
            return OWN_CH1;
        end
        return OWN_CPU;
    endfunction

    // Decode ownership and per-channel completions.
    always_comb begin
        owns[0]  = (owner_q == OWN_CH0);
        owns[1]  = (owner_q == OWN_CH1);
        own_done = owns & unit_done;
    end

    // Decide which open bursts survive this cycle.
    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            act_keep[c] = act_q[c] && legal[c] && !(own_done[c] && xfer_done[c]);
        end
    end

    // Next-owner decision at unit boundaries.
    always_comb begin
        owner_d = owner_q;
        unique case (owner_q)
            OWN_CPU: owner_d = pick(req[0], req[1] || act_keep[1]);
            OWN_CH0: begin
                if (own_done[0]) begin
                    if (act_keep[0]) begin
                        owner_d = OWN_CH0;
                    end else if (!burst[0]) begin
                        owner_d = act_keep[1] ? OWN_CH1 : OWN_CPU;
                    end else begin
                        owner_d = pick(req[0], req[1] || act_keep[1]);
                    end
                end
            end
            OWN_CH1: begin
                if (own_done[1]) begin
                    if (req[0]) begin
                        owner_d = OWN_CH0;
                    end else if (act_keep[1]) begin
                        owner_d = OWN_CH1;
                    end else if (!burst[1]) begin
                        owner_d = OWN_CPU;
                    end else begin
                        owner_d = pick(1'b0, req[1]);
                    end
                end
            end
            default: owner_d = OWN_CPU;
        endcase
    end

    // Open a burst when a burst-mode channel is handed the bus.
    always_comb begin
        act_d[0] = act_keep[0] || (owner_d == OWN_CH0 && burst[0] && legal[0]);
        act_d[1] = act_keep[1] || (owner_d == OWN_CH1 && burst[1] && legal[1]);
    end

    // Ownership and burst-state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q <= OWN_CPU;
            act_q   <= '0;
        end else begin
            owner_q <= owner_d;
            act_q   <= act_d;
        end
    end

    // Drive the one-hot grant from the registered owner.
    always_comb begin
        grant          = '0;
        grant[0]       = (owner_q == OWN_CH0);
        grant[1]       = (owner_q == OWN_CH1);
        grant[CPU_IDX] = (owner_q == OWN_CPU);
    end

    p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(grant));

    p_hold_ch0_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant[0] && !unit_done[0]) |=> grant[0]);

    p_hold_ch1_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant[1] && !unit_done[1]) |=> grant[1]);

    p_preempt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (grant[1] && unit_done[1] && req[0]) |=> grant[0]);

    p_burst0_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (grant[0] && act_q[0] && legal[0] && unit_done[0] && !xfer_done[0]) |=> grant[0]);

    p_alternate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (grant[0] && unit_done[0] && !burst[0] && act_q[1] && legal[1]) |=> grant[1]);

    p_burst1_no_cpu_r7: assert property (@(posedge clk) disable iff (!rst_n)
        act_q[1] |-> !grant[CPU_IDX]);

    p_cs_return_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant[0] && unit_done[0] && !burst[0] && !act_q[1]) |=> grant[CPU_IDX]);
endmodule

// File: rtl/dmaarb_bus_arbiter.sv
// Top of the two-channel DMA bus arbiter.
// Per channel: a legality check and a request source, built by generate;
// one shared grant state machine picks the bus owner.
// Assumes all inputs are synchronous to clk.
module dmaarb_bus_arbiter
    import dmaarb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH-1:0]       ch_en,
    input  logic [NCH-1:0]       ch_burst,
    input  logic [NCH-1:0]       ch_dual,
    input  logic [NCH*SRC_W-1:0] ch_src,
    input  logic [NCH*SZ_W-1:0]  ch_usize,
    input  logic [NCH-1:0]       lvl_req,
    input  logic [NCH-1:0]       ser_req_n,
    input  logic [NCH-1:0]       unit_done,
    input  logic [NCH-1:0]       xfer_done,
    output logic [GNT_W-1:0]     grant,
    output logic [NCH-1:0]       cfg_err
);
    logic [NCH-1:0] legal;
    logic [NCH-1:0] req;
    logic [NCH-1:0] own_done;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic is_ser;
        assign is_ser = (src_e'(ch_src[c*SRC_W +: SRC_W]) == SRC_SER);

        dmaarb_cfg_check u_cfg (
            .en    (ch_en[c]),
            .burst (ch_burst[c]),
            .dual  (ch_dual[c]),
            .src   (ch_src[c*SRC_W +: SRC_W]),
            .usize (ch_usize[c*SZ_W +: SZ_W]),
            .legal (legal[c]),
            .err   (cfg_err[c])
        );

        dmaarb_req_src u_req (
            .clk      (clk),
            .rst_n    (rst_n),
            .legal    (legal[c]),
            .is_ser   (is_ser),
            .lvl_req  (lvl_req[c]),
            .line_n   (ser_req_n[c]),
            .own_done (own_done[c]),
            .req      (req[c])
        );

        // R9: a channel flagged illegal is never handed the bus.
        p_err_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_err[c] && grant[CPU_IDX]) |=> !grant[c]);
    end

    dmaarb_grant_ctl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .burst     (ch_burst),
        .legal     (legal),
        .unit_done (unit_done),
        .xfer_done (xfer_done),
        .grant     (grant),
        .own_done  (own_done)
    );
endmodule

// File: tb/sim_dmaarb_bus_arbiter.sv
`timescale 1ns/1ps
module sim_dmaarb_bus_arbiter;
    localparam logic [2:0] G0  = 3'b001;
    localparam logic [2:0] G1  = 3'b010;
    localparam logic [2:0] GC  = 3'b100;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] ch_en, ch_burst, ch_dual, lvl_req, ser_req_n, unit_done, xfer_done;
    logic [3:0] ch_src, ch_usize;
    logic [2:0] grant;
    logic [1:0] cfg_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    dmaarb_bus_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .ch_burst(ch_burst),
        .ch_dual(ch_dual), .ch_src(ch_src), .ch_usize(ch_usize),
        .lvl_req(lvl_req), .ser_req_n(ser_req_n), .unit_done(unit_done),
        .xfer_done(xfer_done), .grant(grant), .cfg_err(cfg_err)
    );

    task automatic chk(input string rq, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h at %0t", rq, got, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic set_ch(input int c, input logic en, input logic b, input logic d,
                          input logic [1:0] s, input logic [1:0] z);
        ch_en[c]           = en;
        ch_burst[c]        = b;
        ch_dual[c]         = d;
        ch_src[2*c +: 2]   = s;
        ch_usize[2*c +: 2] = z;
    endtask

    function automatic logic exp_err(input logic en, input logic b, input logic d,
                                     input int s, input int z);
        logic bad;
        bad = (s == 3) || (b && s == 2) || (!d && z == 3) || (!d && s != 0);
        return en && bad;
    endfunction

    task automatic idle();
        lvl_req = 2'b00; unit_done = 2'b00; xfer_done = 2'b00; ser_req_n = 2'b11;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        idle();
        set_ch(0, 0, 0, 1, 0, 0);
        set_ch(1, 0, 0, 1, 0, 0);
        step(); step();
        chk("R1 grant in reset", grant, GC);
        chk("R9 no error when disabled", cfg_err, 2'b00);
        rst_n = 1'b1;
        step();
        chk("R1 grant after reset", grant, GC);
        step(); step();
        chk("R2 idle CPU", grant, GC);

        // R9: sweep every configuration on both channels.
        for (int e = 0; e < 2; e++)
            for (int b = 0; b < 2; b++)
                for (int d = 0; d < 2; d++)
                    for (int s = 0; s < 4; s++)
                        for (int z = 0; z < 4; z++) begin
                            set_ch(0, e[0], b[0], d[0], s[1:0], z[1:0]);
                            set_ch(1, e[0], b[0], d[0], 2'(3 - s), z[1:0]);
                            #1;
                            chk("R9 cfg_err ch0", cfg_err[0], exp_err(e[0], b[0], d[0], s, z));
                            chk("R9 cfg_err ch1", cfg_err[1], exp_err(e[0], b[0], d[0], 3 - s, z));
                        end
        set_ch(0, 0, 0, 1, 0, 0);
        set_ch(1, 0, 0, 1, 0, 0);
        step();

        // Scenario A: both burst; channel 0 burst preempts channel 1 burst.
        set_ch(0, 1, 1, 1, 0, 2);
        set_ch(1, 1, 1, 1, 0, 2);
        lvl_req = 2'b10; step();
        chk("R11 level request grants ch1", grant, G1);
        unit_done = 2'b10; step();
        chk("R5 ch1 burst continues", grant, G1);
        lvl_req = 2'b11; step();
        chk("R4 ch0 preempts ch1 burst", grant, G0);
        unit_done = 2'b00; step(); step();
        chk("R3 ch0 holds without unit_done", grant, G0);
        unit_done = 2'b10; step();
        chk("R3 non-owner unit_done ignored", grant, G0);
        unit_done = 2'b01; lvl_req = 2'b10; step();
        chk("R5 ch0 burst keeps bus", grant, G0);
        xfer_done = 2'b01; step();
        chk("R5 ch1 resumes after ch0 transfer", grant, G1);
        unit_done = 2'b10; xfer_done = 2'b10; lvl_req = 2'b00; step();
        chk("R2 CPU after bursts end", grant, GC);
        idle(); step(); step();
        chk("R2 CPU stays idle", grant, GC);

        // Scenario B: ch0 cycle-steal interleaves with ch1 burst.
        set_ch(0, 1, 0, 1, 1, 3);
        lvl_req = 2'b10; step();
        chk("R11 ch1 burst start", grant, G1);
        unit_done = 2'b10; lvl_req = 2'b11; step();
        chk("R4 ch0 cycle-steal preempts", grant, G0);
        unit_done = 2'b01; step();
        chk("R6 back to ch1 after one unit", grant, G1);
        unit_done = 2'b10; step();
        chk("R6 alternate to ch0", grant, G0);
        unit_done = 2'b01; step();
        chk("R6 alternate to ch1", grant, G1);
        chk("R7 CPU not granted", grant[2], 1'b0);
        unit_done = 2'b10; lvl_req = 2'b10; step();
        chk("R7 ch1 keeps bus", grant, G1);
        xfer_done = 2'b10; lvl_req = 2'b00; step();
        chk("R2 CPU after ch1 done", grant, GC);
        idle(); step();

        // Scenario C: ch0 cycle-steal alone.
        set_ch(1, 0, 0, 1, 0, 0);
        lvl_req = 2'b01; step();
        chk("R11 ch0 granted", grant, G0);
        step(); step(); step();
        chk("R3 ch0 holds mid-unit", grant, G0);
        unit_done = 2'b01; step();
        chk("R8 CPU after cycle-steal unit", grant, GC);
        unit_done = 2'b00; step();
        chk("R8 ch0 wins bus back", grant, G0);
        unit_done = 2'b01; lvl_req = 2'b00; step();
        chk("R8 CPU after last unit", grant, GC);
        idle(); step();
        chk("R2 CPU no request", grant, GC);

        // Scenario D: serial request on ch1, edge detected.
        set_ch(0, 0, 0, 1, 0, 0);
        set_ch(1, 1, 0, 1, 2, 0);
        lvl_req = 2'b10; step(); step();
        chk("R10 level ignored for serial source", grant, GC);
        lvl_req = 2'b00;
        ser_req_n = 2'b01; step();
        chk("R10 not yet granted one edge after fall", grant, GC);
        step();
        chk("R10 granted after falling edge", grant, G1);
        step(); step();
        chk("R10 pending held until unit done", grant, G1);
        unit_done = 2'b10; step();
        chk("R8 serial cycle-steal returns bus", grant, GC);
        unit_done = 2'b00; step(); step(); step();
        chk("R10 held-low line gives one request", grant, GC);
        ser_req_n = 2'b11; step();
        ser_req_n = 2'b01; step(); step();
        chk("R10 second edge second request", grant, G1);
        unit_done = 2'b10; ser_req_n = 2'b11; step();
        unit_done = 2'b00; step();
        chk("R10 cleared after second unit", grant, GC);
        set_ch(0, 1, 0, 1, 0, 0);
        ser_req_n = 2'b00; step();
        chk("R11 serial line ignored for external ch0", grant[0], 1'b0);
        step();
        chk("R11 serial line ignored, ch1 served", grant, G1);
        unit_done = 2'b10; step();
        unit_done = 2'b00; ser_req_n = 2'b11; step();
        set_ch(0, 0, 0, 1, 0, 0);

        // R1: reset discards a latched request.
        ser_req_n = 2'b01; step();
        rst_n = 1'b0; step(); step();
        chk("R1 grant in mid-sequence reset", grant, GC);
        rst_n = 1'b1; step(); step(); step();
        chk("R1 pending cleared by reset", grant, GC);
        ser_req_n = 2'b11; step();

        // Scenario E: illegal setups never get the bus.
        set_ch(1, 0, 0, 1, 0, 0);
        set_ch(0, 1, 1, 1, 2, 0);
        #1 chk("R9 burst with serial flagged", cfg_err, 2'b01);
        ser_req_n = 2'b10; step(); step(); step();
        chk("R9 illegal serial ch0 not granted", grant, GC);
        ser_req_n = 2'b11;
        set_ch(0, 1, 0, 0, 1, 0);
        lvl_req = 2'b01; step(); step();
        chk("R9 auto source in single address blocked", grant, GC);
        set_ch(0, 1, 0, 0, 0, 3); step(); step();
        chk("R9 16-byte single address blocked", grant, GC);
        set_ch(0, 1, 0, 1, 1, 3); step();
        chk("R11 legal auto ch0 granted", grant, G0);
        unit_done = 2'b01; lvl_req = 2'b00; step();
        idle(); step();
        chk("R2 final idle", grant, GC);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule